// File: doc/BRIEF.md
# Rate-1/2 Constraint-Length-7 Convolutional Encoder

This block turns a serial stream of data bits into a stream of 2-bit code symbols for a forward-error-correction path. Each accepted bit is combined with the six bits that came before it. Two fixed tap masks over that 7-bit window each produce one parity bit, so every input bit yields one output symbol. The encoder is feed-forward: the memory only shifts, and no parity is fed back into it.

Data enters through a valid/ready handshake and leaves through a registered valid/ready output. A downstream stall holds the symbol and stops input. A flush command closes a frame by pushing six zero tail bits through the window. This emits six more symbols and leaves the memory cleared, so the next frame starts from the zero state.

Top module: `conv_enc_k7`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `in_ready` is 1, and all six memory stages are zero.
- R2: A bit is taken only in a cycle where `in_valid` and `in_ready` are both 1. While `in_valid` stays low and no flush runs, no symbol is produced.
- R3: `out_sym[1]` is the XOR of the window taps at delays 0, 2, 3, 5 and 6. Delay 0 is the bit being encoded and delay k is the bit taken k steps earlier.
- R4: `out_sym[0]` is the XOR of the window taps at delays 0, 1, 2, 3 and 6.
- R5: A symbol appears with `out_valid` one cycle after its bit is taken. While `out_ready` is 0, `out_valid` and `out_sym` hold unchanged and `in_ready` is 0.
- R6: A `flush_req` pulse seen while no flush runs encodes six zero bits and emits six symbols. `in_ready` is 0 until the last tail bit has been encoded.
- R7: After a flush completes, all memory stages are zero. A following lone 1 therefore reproduces the response of R9.
- R8: A data bit taken in the same cycle as an accepted `flush_req` is encoded before the tail bits.
- R9: From the zero state, a single 1 followed by six 0s yields the symbols 11, 01, 11, 11, 00, 10, 11 in order, written as `out_sym[1]` then `out_sym[0]`.
- R10: A `flush_req` that arrives while a flush is already running has no effect: exactly six tail symbols are produced in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit is offered |
| in_ready | output | 1 | Encoder can take a bit this cycle |
| in_bit | input | 1 | Data bit |
| flush_req | input | 1 | Single-cycle request to append the zero tail |
| out_valid | output | 1 | Output symbol is present |
| out_ready | input | 1 | Downstream takes the symbol this cycle |
| out_sym | output | 2 | Code symbol: bit 1 from the first mask, bit 0 from the second |

## Verification
Two situations are the hardest to reach from the ports. The first is a second flush request that lands while the tail is still draining. The bench reaches it by throttling `out_ready` with a repeating stall pattern, which stretches the six tail steps over many cycles, and then pulsing `flush_req` again during that stretch. The second is a data handshake that falls in the same cycle as a flush request. The bench reaches it by raising both with an empty output slot. In both cases the scoreboard queue fixes the required order and count of data and tail symbols.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  localparam int unsigned CE_K      = 7;
  localparam int unsigned CE_NOUT   = 2;
  localparam logic [CE_K-1:0] CE_MASK_HI = 7'b1101101; // delays 0,2,3,5,6
  localparam logic [CE_K-1:0] CE_MASK_LO = 7'b1001111; // delays 0,1,2,3,6

  typedef enum logic [0:0] {
    MODE_DATA = 1'b0,
    MODE_TAIL = 1'b1
  } ce_mode_e;
endpackage

// File: rtl/conv_enc_window.sv
module conv_enc_window #(
  parameter int unsigned K = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         bit_in,
  output logic [K-1:0] window,
  output logic [K-2:0] mem_q
);
  // mem_q[i] holds the bit from delay i+1
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= '0;
    end else if (step) begin
      mem_q <= {mem_q[K-3:0], bit_in};
    end
  end

  assign window = {mem_q, bit_in};

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(mem_q));
endmodule

// File: rtl/conv_enc_tap.sv
module conv_enc_tap #(
  parameter int unsigned K    = 7,
  parameter logic [K-1:0] MASK = '1
) (
  input  logic [K-1:0] window,
  output logic         parity
);
  logic [K-1:0] chain;

  generate
    for (genvar i = 0; i < K; i++) begin : g_tap
      if (i == 0) begin : g_first
        assign chain[i] = MASK[i] & window[i];
      end else begin : g_rest
        assign chain[i] = chain[i-1] ^ (MASK[i] & window[i]);
      end
    end
  endgenerate

  assign parity = chain[K-1];
endmodule

// File: rtl/conv_enc_ctrl.sv
module conv_enc_ctrl
  import conv_enc_pkg::*;
#(
  parameter int unsigned K = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic flush_req,
  input  logic out_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic step,
  output logic feed_zero
);
  localparam int unsigned CW    = $clog2(K);
  localparam logic [CW-1:0] TAIL_LEN = CW'(K - 1);

  ce_mode_e      mode_q;
  logic [CW-1:0] tail_q;
  logic          slot_free;
  logic          tail_fire;

  assign slot_free = !out_valid || out_ready;
  assign in_ready  = (mode_q == MODE_DATA) && slot_free;
  assign tail_fire = (mode_q == MODE_TAIL) && slot_free;
  assign step      = (in_valid && in_ready) || tail_fire;
  assign feed_zero = (mode_q == MODE_TAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_DATA;
      tail_q <= '0;
    end else begin
      case (mode_q)
        MODE_DATA: begin
          if (flush_req) begin
            mode_q <= MODE_TAIL;
            tail_q <= TAIL_LEN;
          end
        end
        MODE_TAIL: begin
          if (tail_fire) begin
            if (tail_q == CW'(1)) begin
              mode_q <= MODE_DATA;
              tail_q <= '0;
            end else begin
              tail_q <= tail_q - CW'(1);
            end
          end
        end
        default: mode_q <= MODE_DATA;
      endcase
    end
  end

  // R6
  tail_range_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_TAIL) |-> (tail_q != '0 && tail_q <= TAIL_LEN));

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_TAIL && !tail_fire) |=> $stable(tail_q));
endmodule

// File: rtl/conv_enc_outreg.sv
module conv_enc_outreg #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      q     <= '0;
    end else if (load) begin
      valid <= 1'b1;
      q     <= d;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(q)));
endmodule

// File: rtl/conv_enc_k7.sv
module conv_enc_k7
  import conv_enc_pkg::*;
#(
  parameter int unsigned K = CE_K,
  parameter logic [K-1:0] MASK_HI = CE_MASK_HI,
  parameter logic [K-1:0] MASK_LO = CE_MASK_LO
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_bit,
  input  logic                flush_req,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [CE_NOUT-1:0]  out_sym
);
  logic               step;
  logic               feed_zero;
  logic               enc_bit;
  logic [K-1:0]       window;
  logic [K-2:0]       mem_q;
  logic [CE_NOUT-1:0] sym_d;

  assign enc_bit = feed_zero ? 1'b0 : in_bit;

  conv_enc_ctrl #(.K(K)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .flush_req(flush_req),
    .out_valid(out_valid), .out_ready(out_ready), .in_ready(in_ready),
    .step(step), .feed_zero(feed_zero)
  );

  conv_enc_window #(.K(K)) u_win (
    .clk(clk), .rst(rst), .step(step), .bit_in(enc_bit),
    .window(window), .mem_q(mem_q)
  );

  generate
    for (genvar g = 0; g < CE_NOUT; g++) begin : g_par
      conv_enc_tap #(.K(K), .MASK((g == 1) ? MASK_HI : MASK_LO)) u_tap (
        .window(window), .parity(sym_d[g])
      );
    end
  endgenerate

  conv_enc_outreg #(.W(CE_NOUT)) u_out (
    .clk(clk), .rst(rst), .load(step), .d(sym_d), .ready(out_ready),
    .valid(out_valid), .q(out_sym)
  );

  // R6
  tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (step && feed_zero) |=> (mem_q[0] == 1'b0));

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(feed_zero) |-> (mem_q == '0));

  // R2
  sym_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(step));
endmodule

// File: tb/conv_enc_k7_bench.sv
module conv_enc_k7_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       flush_req = 1'b0;
  logic       out_ready = 1'b1;
  logic       in_ready;
  logic       out_valid;
  logic [1:0] out_sym;

  int         n_chk = 0;
  int         n_fail = 0;
  int         n_sym = 0;
  int         cyc = 0;
  int         rdy_mode = 0;
  logic [1:0] exp_q[$];
  logic [5:0] m_mem = '0;
  logic [13:0] hist = '0;

  always #2.5 clk = ~clk;

  conv_enc_k7 u_conv_enc_k7 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .flush_req(flush_req), .out_valid(out_valid),
    .out_ready(out_ready), .out_sym(out_sym)
  );

  function automatic logic [1:0] ref_sym(input logic [5:0] m, input logic b);
    logic [6:0] w;
    w = {m, b};
    return {w[0]^w[2]^w[3]^w[5]^w[6], w[0]^w[1]^w[2]^w[3]^w[6]};
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_bit(input logic b);
    exp_q.push_back(ref_sym(m_mem, b));
    m_mem = {m_mem[4:0], b};
  endtask

  task automatic push_tail();
    for (int i = 0; i < 6; i++) push_bit(1'b0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      n_sym++;
      hist = {hist[11:0], out_sym};
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R10 unexpected symbol", out_sym, 0);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        chk(out_sym == e, "R3/R4 symbol", out_sym, e);
      end
    end
  end

  task automatic send_bit(input logic b);
    logic done;
    done = 1'b0;
    in_valid = 1'b1;
    in_bit = b;
    while (!done) begin
      @(negedge clk);
      if (in_ready) begin
        push_bit(b);
        done = 1'b1;
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic do_flush(input logic with_bit, input logic b);
    flush_req = 1'b1;
    in_valid = with_bit;
    in_bit = b;
    @(negedge clk);
    if (with_bit) begin
      chk(in_ready == 1'b1, "R8 ready with flush", in_ready, 1);
      if (in_ready) push_bit(b);
    end
    push_tail();
    @(posedge clk); #1;
    flush_req = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R6 ready low in flush", in_ready, 0);
    @(posedge clk); #1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
    summary();
  end

  initial begin
    int base;
    logic [7:0] lf;
    logic [1:0] held;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    @(posedge clk); #1;

    // R9 impulse from reset state (also R1 zero memory)
    send_bit(1'b1);
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    drain();
    chk(hist == 14'b11_01_11_11_00_10_11, "R9 impulse response", hist, 14'b11011111001011);

    // R3 R4 pseudo-random bits under backpressure
    rdy_mode = 1;
    lf = 8'hA5;
    for (int i = 0; i < 48; i++) begin
      send_bit(lf[0]);
      lf = {lf[6:0], lf[7]^lf[5]^lf[4]^lf[3]};
    end
    drain();
    rdy_mode = 0;

    // R2 idle input gives no symbols
    base = n_sym;
    repeat (8) @(posedge clk);
    #1;
    chk(n_sym == base, "R2 idle no symbols", n_sym, base);

    // R5 hold under stall
    rdy_mode = 2;
    @(posedge clk); #1;
    send_bit(1'b1);
    @(negedge clk);
    held = out_sym;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R5 valid held", out_valid, 1);
      chk(out_sym == held, "R5 symbol stable", out_sym, held);
      chk(in_ready == 1'b0, "R5 ready low on stall", in_ready, 0);
    end
    rdy_mode = 0;
    drain();

    // R6 R7 flush after nonzero content, then impulse
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    drain();
    base = n_sym;
    do_flush(1'b0, 1'b0);
    drain();
    chk(n_sym == base + 6, "R6 six tail symbols", n_sym - base, 6);
    chk(in_ready == 1'b1, "R6 ready after flush", in_ready, 1);
    send_bit(1'b1);
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    drain();
    chk(hist == 14'b11_01_11_11_00_10_11, "R7 impulse after flush", hist, 14'b11011111001011);

    // R8 data bit in the flush cycle
    send_bit(1'b1);
    send_bit(1'b1);
    drain();
    base = n_sym;
    do_flush(1'b1, 1'b1);
    drain();
    chk(n_sym == base + 7, "R8 data plus tail count", n_sym - base, 7);

    // R10 second request during flush under backpressure
    send_bit(1'b1);
    drain();
    rdy_mode = 1;
    base = n_sym;
    do_flush(1'b0, 1'b0);
    flush_req = 1'b1;
    @(posedge clk); #1;
    flush_req = 1'b0;
    drain();
    repeat (10) @(posedge clk);
    #1;
    chk(n_sym == base + 6, "R10 retrigger ignored", n_sym - base, 6);
    chk(in_ready == 1'b1, "R10 ready after flush", in_ready, 1);
    rdy_mode = 0;

    chk(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);
    summary();
  end
endmodule